// File: doc/BRIEF.md
# Hardwired Signed Booth Multiply Sequencer

This block runs a signed two's-complement multiplication of two WIDTH-bit register operands on a small add/shift datapath. It produces a 2*WIDTH-bit product. A single start request (the multiply bit of an instruction) launches the whole operation. From then on, a gate-and-flip-flop state machine steps through one Booth iteration per clock. No further instructions are needed. A down counter with load, decrement and zero-detect paces the run. When the last iteration is done, the block presents the product for one cycle with a write strobe: the upper half goes back to register B and the lower half to register A. It then raises a completion flag.

The controller has three states. IDLE waits for a start and holds the completion flag. RUN performs one radix-2 Booth step each cycle. FINISH drives the write strobe. The transitions are:

- IDLE to RUN when start is seen. The operands are latched, the partial product is cleared and the counter is loaded with WIDTH-1.
- RUN to RUN while the counter is non-zero. The counter decrements each of these cycles.
- RUN to FINISH in the cycle the counter reads zero. That cycle is the last step.
- FINISH to IDLE unconditionally. The completion flag is set on this transition.

Each Booth step examines the multiplier's low bit together with the previously shifted-out bit. For the pair 01 it adds the multiplicand, for 10 it subtracts it, and for 00 or 11 it adds nothing. It then shifts the accumulator, multiplier and extra bit one place right arithmetically.

Top module: `bmul_seq`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are all 0.
- R2: A 1 on `mul_start` while idle latches `opnd_a` and `opnd_b`, and `busy` is 1 from the next cycle on. Later changes on `opnd_a`/`opnd_b` do not affect the result.
- R3: In the write cycle, `{prod_hi, prod_lo}` equals the 2*WIDTH-bit two's-complement product `opnd_a * opnd_b`. `prod_hi` (bits 2*WIDTH-1..WIDTH) is for register B and `prod_lo` (bits WIDTH-1..0) is for register A.
- R4: The step counter is loaded with WIDTH-1 on start and decrements once per RUN cycle. The run ends in the cycle its zero flag is seen, so there are exactly WIDTH step cycles and `wr_en` is 1 in the cycle after the clock edge WIDTH edges after the start edge.
- R5: `wr_en` is a single-cycle pulse, given exactly once per multiplication and at no other time.
- R6: `done` becomes 1 the cycle after the write cycle, when `busy` drops to 0. It stays 1 through idle cycles until the next accepted start, and is 0 from the cycle after that start.
- R7: `mul_start` asserted while `busy` is 1 is ignored: write timing and product are those of the run already in progress.
- R8: Booth recoding: a step with pair (q0, q-1) = 01 adds the multiplicand, 10 subtracts it, 00 and 11 leave the accumulator unchanged before the arithmetic right shift. The extreme operand -2^(WIDTH-1) gives correct products in both operand positions, including (-2^(WIDTH-1))^2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counter and datapath share its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mul_start | input | 1 | Multiply bit of the current instruction |
| opnd_a | input | WIDTH | Multiplicand, read from register A |
| opnd_b | input | WIDTH | Multiplier, read from register B |
| busy | output | 1 | High in RUN and FINISH |
| done | output | 1 | Completion flag, held until the next start |
| wr_en | output | 1 | Register-file write strobe for both halves |
| prod_hi | output | WIDTH | Upper product half, destined for register B |
| prod_lo | output | WIDTH | Lower product half, destined for register A |

## Verification
The bench builds the block with WIDTH = 16, which makes the counter 4 bits wide and its load value 15. At this width, every operand pair can be checked exactly against a 64-bit product computed in the bench, including both 16-bit extremes. The 16-step run is short enough to check the write-strobe cycle, the held completion flag and starts issued mid-run, cycle by cycle, over a hundred random operand pairs.

// File: rtl/bmul_pkg.sv
package bmul_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } bmul_state_e;

    typedef enum logic [1:0] {
        BOOTH_NONE = 2'd0,
        BOOTH_ADD  = 2'd1,
        BOOTH_SUB  = 2'd2
    } booth_op_e;
endpackage

// File: rtl/bmul_step_counter.sv
module bmul_step_counter #(
    parameter int CNT_W     = 4,
    parameter int START_VAL = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_load,
    input  logic cnt_dec,
    output logic cnt_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_load)
            cnt_q <= CNT_W'(START_VAL);
        else if (cnt_dec)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign cnt_zero = (cnt_q == '0);

    // R4: load brings the start value
    p_cnt_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt_q == CNT_W'(START_VAL)));

    // R4: a decrement lowers the count by exactly one
    p_cnt_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_dec && !cnt_load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R4: with neither input, the count holds
    p_cnt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_dec && !cnt_load) |=> $stable(cnt_q));
endmodule

// File: rtl/bmul_datapath.sv
module bmul_datapath
    import bmul_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dp_load,
    input  logic             dp_step,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int AW = WIDTH + 1;

    logic [AW-1:0]    acc_q;
    logic [WIDTH-1:0] mq_q;
    logic             qm1_q;
    logic [WIDTH-1:0] mcand_q;
    logic [AW-1:0]    mcand_ext;
    logic [AW-1:0]    addend;
    logic [AW-1:0]    sum;
    booth_op_e        op;

    assign mcand_ext = {mcand_q[WIDTH-1], mcand_q};

    always_comb begin
        unique case ({mq_q[0], qm1_q})
            2'b01:   op = BOOTH_ADD;
            2'b10:   op = BOOTH_SUB;
            default: op = BOOTH_NONE;
        endcase
    end

    always_comb begin
        unique case (op)
            BOOTH_ADD: addend = mcand_ext;
            BOOTH_SUB: addend = ~mcand_ext + AW'(1);
            default:   addend = '0;
        endcase
    end

    assign sum = acc_q + addend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mq_q    <= '0;
            qm1_q   <= 1'b0;
            mcand_q <= '0;
        end else if (dp_load) begin
            acc_q   <= '0;
            mq_q    <= mplier_i;
            qm1_q   <= 1'b0;
            mcand_q <= mcand_i;
        end else if (dp_step) begin
            acc_q   <= {sum[AW-1], sum[AW-1:1]};
            mq_q    <= {sum[0], mq_q[WIDTH-1:1]};
            qm1_q   <= mq_q[0];
        end
    end

    assign hi_o = acc_q[WIDTH-1:0];
    assign lo_o = mq_q;

    // R8: pairs 00/11 only shift the accumulator
    p_booth_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_step && !dp_load && (mq_q[0] == qm1_q))
        |=> (acc_q == {$past(acc_q[AW-1]), $past(acc_q[AW-1:1])}));

    // R8: the bit leaving the multiplier becomes the new extra bit
    p_booth_qm1_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_step && !dp_load) |=> (qm1_q == $past(mq_q[0])));

    // R2: the multiplicand is held for the whole run
    p_mcand_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_load |=> $stable(mcand_q));

    // R3: with no load or step, the product halves hold
    p_prod_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp_load && !dp_step) |=> ($stable(acc_q) && $stable(mq_q)));
endmodule

// File: rtl/bmul_ctrl.sv
module bmul_ctrl
    import bmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mul_start,
    input  logic cnt_zero,
    output logic cnt_load,
    output logic cnt_dec,
    output logic dp_load,
    output logic dp_step,
    output logic wr_en,
    output logic busy,
    output logic done
);
    bmul_state_e state_q, state_d;
    logic        done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (mul_start) state_d = ST_RUN;
            ST_RUN:    if (cnt_zero)  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        dp_load  = 1'b0;
        dp_step  = 1'b0;
        wr_en    = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_load = mul_start;
                dp_load  = mul_start;
            end
            ST_RUN: begin
                busy    = 1'b1;
                dp_step = 1'b1;
                cnt_dec = !cnt_zero;
            end
            ST_FINISH: begin
                busy  = 1'b1;
                wr_en = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (state_q == ST_FINISH)
            done_q <= 1'b1;
        else if (state_q == ST_IDLE && mul_start)
            done_q <= 1'b0;
    end

    assign done = done_q;

    // R2: an accepted start makes the block busy next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && mul_start) |=> busy);

    // R4: the zero flag in RUN ends the run
    p_zero_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && cnt_zero) |=> (state_q == ST_FINISH));

    // R5: the write strobe lasts one cycle
    p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R6: done holds until a start arrives
    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mul_start) |=> done);

    // R6: done rises right after the write
    p_done_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (done && !busy));

    // R7: start during a run does not restart it
    p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !cnt_zero) |=> (state_q == ST_RUN));
endmodule

// File: rtl/bmul_seq.sv
module bmul_seq #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mul_start,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic             busy,
    output logic             done,
    output logic             wr_en,
    output logic [WIDTH-1:0] prod_hi,
    output logic [WIDTH-1:0] prod_lo
);
    localparam int CNT_W     = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam int START_VAL = WIDTH - 1;

    logic cnt_load, cnt_dec, cnt_zero;
    logic dp_load, dp_step;

    bmul_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mul_start(mul_start),
        .cnt_zero (cnt_zero),
        .cnt_load (cnt_load),
        .cnt_dec  (cnt_dec),
        .dp_load  (dp_load),
        .dp_step  (dp_step),
        .wr_en    (wr_en),
        .busy     (busy),
        .done     (done)
    );

    bmul_step_counter #(
        .CNT_W    (CNT_W),
        .START_VAL(START_VAL)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_load(cnt_load),
        .cnt_dec (cnt_dec),
        .cnt_zero(cnt_zero)
    );

    bmul_datapath #(
        .WIDTH(WIDTH)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .dp_load (dp_load),
        .dp_step (dp_step),
        .mcand_i (opnd_a),
        .mplier_i(opnd_b),
        .hi_o    (prod_hi),
        .lo_o    (prod_lo)
    );

    // R5: no write strobe while idle and not busy
    p_wr_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

    // R1: control outputs are mutually consistent
    p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/bmul_seq_tb.sv
module bmul_seq_tb_top;
    localparam int WIDTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mul_start = 1'b0;
    logic [WIDTH-1:0] opnd_a = '0;
    logic [WIDTH-1:0] opnd_b = '0;
    logic             busy, done, wr_en;
    logic [WIDTH-1:0] prod_hi, prod_lo;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bmul_seq #(.WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .mul_start(mul_start),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .busy(busy), .done(done), .wr_en(wr_en),
        .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    function automatic logic [2*WIDTH-1:0] ref_prod(input logic [WIDTH-1:0] a,
                                                    input logic [WIDTH-1:0] b);
        longint sa, sb, p;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        p  = sa * sb;
        return p[2*WIDTH-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic run_mul(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                           input bit poke_busy);
        logic [2*WIDTH-1:0] exp_p;
        exp_p = ref_prod(a, b);
        @(negedge clk);
        opnd_a = a; opnd_b = b; mul_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mul_start = 1'b0;
        opnd_a = WIDTH'($urandom);
        opnd_b = WIDTH'($urandom);
        chk(busy == 1'b1, "R2 busy after start", longint'(busy), 1);
        chk(done == 1'b0, "R6 done cleared by start", longint'(done), 0);
        for (int k = 1; k < WIDTH; k++) begin
            if (poke_busy && k == 5) mul_start = 1'b1;
            if (poke_busy && k == 6) mul_start = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (wr_en) chk(1'b0, "R4 early write", longint'(k), WIDTH);
        end
        mul_start = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(wr_en == 1'b1, poke_busy ? "R7 write timing kept" : "R4 write cycle",
            longint'(wr_en), 1);
        chk({prod_hi, prod_lo} == exp_p, poke_busy ? "R7 product kept" : "R3 product",
            longint'({prod_hi, prod_lo}), longint'(exp_p));
        @(posedge clk);
        @(negedge clk);
        chk(done && !busy && !wr_en, "R5 R6 single write then done",
            longint'({done, busy, wr_en}), 3'b100);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20241));
        repeat (3) @(negedge clk);
        chk({busy, done, wr_en} == 3'b000, "R1 reset outputs",
            longint'({busy, done, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, wr_en} == 3'b000, "R1 after release",
            longint'({busy, done, wr_en}), 0);

        // R8 corner cases with the extreme operand
        run_mul(16'h8000, 16'h8000, 1'b0);
        run_mul(16'h8000, 16'h7FFF, 1'b0);
        run_mul(16'h7FFF, 16'h8000, 1'b0);
        run_mul(16'hFFFF, 16'hFFFF, 1'b0);
        run_mul(16'h0000, 16'h1234, 1'b0);
        run_mul(16'h5555, 16'hAAAA, 1'b0);

        // R6: done holds through idle cycles
        repeat (4) begin
            @(negedge clk);
            chk(done == 1'b1, "R6 done held", longint'(done), 1);
            chk(wr_en == 1'b0, "R5 no idle write", longint'(wr_en), 0);
        end

        // R7: start while busy
        run_mul(16'h1357, 16'hFEDC, 1'b1);
        run_mul(16'h8001, 16'h0003, 1'b1);

        for (int i = 0; i < 100; i++)
            run_mul(WIDTH'($urandom), WIDTH'($urandom), (i % 7) == 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule